// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer Channel

This block is one timer channel with two 16-bit registers, A and B. It watches one of four external free-running counter buses. In the input modes it latches the selected count when an edge arrives on its pin. In the output modes it compares both registers against the bus on every clock and drives a shared output flip-flop from the matches. A one-cycle flag pulse marks each capture or counted match. The counters themselves, their prescalers, interrupt routing and the analog pad are all outside the block.

A single control word holds all the settings: operating mode, edge/level polarity, open-drain drive, freeze response and bus choice. It also carries two self-clearing force actions that move the output flip-flop the way a match would, but without raising the flag. Registers A and B can be loaded by software through a separate write port. A capture in the same cycle takes priority over such a write.

Top module: `dual_cc_timer`

## Requirements
- R1: After reset, ctrl_rdata_o holds zero apart from bit 0 (the synchronized pin level), the mode is disabled, both registers are zero, and pin_oe_o and flag_o are low.
- R2: Control field positions are: bit 0 pin level (read-only), bit 1 open-drain, bit 2 freeze enable, bit 3 polarity, bit 4 force-set, bit 5 force-clear, bits 7:6 bus select, bits 11:8 mode. Bits 5:4 and 15:12 always read 0. Open-drain and polarity read back their last written value in every mode.
- R3: Bus select k routes cnt_bus_i[16k+15:16k] to both capture and compare.
- R4: Mode codes are 0 disabled, 1 pulse-width capture, 2 period capture, 3 single capture, 4 compare on B, 5 compare on A and B, 6 PWM. Other codes act as disabled. A write that would move from one non-zero mode to a different non-zero mode leaves the mode unchanged.
- R5: The pin passes a 2-flop synchronizer. A capture and its flag pulse appear on the third rising clock edge after the pin changes, and the flag lasts one cycle. In mode 1, polarity 0 captures into A on a rising edge and into B on a falling edge. Polarity 1 swaps the two edges.
- R6: In mode 2, a capture edge (rising if polarity 0, falling if 1) copies the old A into B and loads the bus into A.
- R7: In mode 3, a capture edge (same polarity rule as R6) loads A only, and B is unchanged.
- R8: In mode 5, a match of A with the bus sets the flip-flop and a match of B clears it, with the flag pulsing for either. When both match in the same cycle, the clear wins.
- R9: In mode 4, a match on A has no effect, and a match on B clears the flip-flop and pulses the flag. Mode 6 sets and clears like mode 5 but pulses the flag only on a B match.
- R10: In output modes the pin level is the flip-flop value, inverted when polarity is 1. With open-drain 0, pin_oe_o=1 and pin_out_o carries the level. With open-drain 1, pin_out_o=0 and pin_oe_o is the inverse of the level.
- R11: In output modes, writing force-set sets the flip-flop and writing force-clear clears it. Writing both clears it. No force raises the flag.
- R12: With freeze enable 1 and freeze_i high, no capture, compare or flag occurs. With freeze enable 0, freeze_i has no effect.
- R13: Outside the output modes, pin_oe_o and pin_out_o are 0, the force bits are ignored, and the flip-flop is held at 0.
- R14: Bit 0 of ctrl_rdata_o follows pin_i two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_bus_i | input | 64 | Four 16-bit counter buses, bus k at bits 16k+15:16k |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| ctrl_rdata_o | output | 16 | Control word read value |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select, 0 = A, 1 = B |
| reg_wdata_i | input | 16 | Register write data |
| reg_a_o | output | 16 | Register A value |
| reg_b_o | output | 16 | Register B value |
| freeze_i | input | 1 | External freeze request |
| pin_i | input | 1 | Pin input level |
| pin_out_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |
| flag_o | output | 1 | One-cycle capture/match pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit counter width and four buses. This makes every bus-select code and the full mode field reachable. The bench holds each counter bus at fixed values while it works, so every capture and match has one exact expected count and one exact cycle. Buses 0 to 3 are all exercised. Same-cycle A/B matches, forced transitions with the flag held low, and blocked active-to-active mode changes all fall within reach.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [3:0] {
    MD_DIS  = 4'd0,
    MD_IPW  = 4'd1,
    MD_IPER = 4'd2,
    MD_ICAP = 4'd3,
    MD_OCB  = 4'd4,
    MD_OCAB = 4'd5,
    MD_OPWM = 4'd6
  } mode_e;

  localparam int CTRL_W = 16;
  localparam int F_PIN  = 0;
  localparam int F_OD   = 1;
  localparam int F_FRZ  = 2;
  localparam int F_POL  = 3;
  localparam int F_FSET = 4;
  localparam int F_FCLR = 5;
  localparam int F_BUS  = 6;
  localparam int F_MODE = 8;
  localparam int MODE_W = 4;

  function automatic logic is_out_mode(logic [3:0] m);
    return (m == MD_OCB) || (m == MD_OCAB) || (m == MD_OPWM);
  endfunction
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;  // [0],[1] synchronizer, [2] previous synced level

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  assign level_o = sh_q[1];
  assign rise_o  = sh_q[1] & ~sh_q[2];
  assign fall_o  = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic pol_i,
  input  logic od_i,
  output logic pin_out_o,
  output logic pin_oe_o
);
  logic ff_q;
  logic level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ff_q <= 1'b0;
    else if (!en_i)  ff_q <= 1'b0;
    else if (clr_i)  ff_q <= 1'b0;  // clear dominates set
    else if (set_i)  ff_q <= 1'b1;
  end

  assign level     = ff_q ^ pol_i;
  assign pin_out_o = en_i & ~od_i & level;
  assign pin_oe_o  = en_i & (od_i ? ~level : 1'b1);
endmodule

// File: rtl/dual_cc_timer.sv
module dual_cc_timer
  import tmr_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NBUS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NBUS*CW-1:0] cnt_bus_i,
  input  logic               ctrl_we_i,
  input  logic [CTRL_W-1:0]  ctrl_wdata_i,
  output logic [CTRL_W-1:0]  ctrl_rdata_o,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [CW-1:0]      reg_wdata_i,
  output logic [CW-1:0]      reg_a_o,
  output logic [CW-1:0]      reg_b_o,
  input  logic               freeze_i,
  input  logic               pin_i,
  output logic               pin_out_o,
  output logic               pin_oe_o,
  output logic               flag_o
);
  localparam int BSW = $clog2(NBUS);

  mode_e          mode_q;
  logic           od_q, frz_q, pol_q;
  logic [BSW-1:0] bsel_q;
  logic [CW-1:0]  a_q, b_q;
  logic           flag_q;

  // bus selection
  logic [CW-1:0] bus_arr [NBUS];
  logic [CW-1:0] bus;
  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    assign bus_arr[g] = cnt_bus_i[g*CW +: CW];
  end
  assign bus = bus_arr[bsel_q];

  // control register
  logic [MODE_W-1:0] new_mode;
  logic              hop;
  assign new_mode = ctrl_wdata_i[F_MODE +: MODE_W];
  assign hop = (mode_q != MD_DIS) && (new_mode != MD_DIS) && (new_mode != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_DIS;
      od_q   <= 1'b0;
      frz_q  <= 1'b0;
      pol_q  <= 1'b0;
      bsel_q <= '0;
    end else if (ctrl_we_i) begin
      od_q   <= ctrl_wdata_i[F_OD];
      frz_q  <= ctrl_wdata_i[F_FRZ];
      pol_q  <= ctrl_wdata_i[F_POL];
      bsel_q <= ctrl_wdata_i[F_BUS +: BSW];
      if (!hop) mode_q <= mode_e'(new_mode);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{ctrl_wdata_i[F_PIN], ctrl_wdata_i[CTRL_W-1:F_MODE+MODE_W]};

  // input edges
  logic pin_lvl, rise, fall;
  tmr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .level_o(pin_lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic active, is_out, edge_a, edge_b, match_a, match_b;
  logic cap_a, cap_b, shift_b, cmp_set, cmp_clr, evt, f_set, f_clr;

  assign active  = ~(frz_q & freeze_i);
  assign is_out  = is_out_mode(mode_q);
  assign edge_a  = pol_q ? fall : rise;
  assign edge_b  = pol_q ? rise : fall;
  assign match_a = (a_q == bus);
  assign match_b = (b_q == bus);

  always_comb begin
    cap_a = 1'b0; cap_b = 1'b0; shift_b = 1'b0;
    cmp_set = 1'b0; cmp_clr = 1'b0; evt = 1'b0;
    if (active) begin
      unique case (mode_q)
        MD_IPW:  begin cap_a = edge_a; cap_b = edge_b; evt = edge_a | edge_b; end
        MD_IPER: begin cap_a = edge_a; shift_b = edge_a; evt = edge_a; end
        MD_ICAP: begin cap_a = edge_a; evt = edge_a; end
        MD_OCB:  begin cmp_clr = match_b; evt = match_b; end
        MD_OCAB: begin cmp_set = match_a; cmp_clr = match_b; evt = match_a | match_b; end
        MD_OPWM: begin cmp_set = match_a; cmp_clr = match_b; evt = match_b; end
        default: ;
      endcase
    end
  end

  // software force, no flag
  assign f_set = ctrl_we_i & is_out & ctrl_wdata_i[F_FSET];
  assign f_clr = ctrl_we_i & is_out & ctrl_wdata_i[F_FCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= evt;
      if (cap_a)                       a_q <= bus;
      else if (reg_we_i && !reg_sel_i) a_q <= reg_wdata_i;
      if (cap_b)                       b_q <= bus;
      else if (shift_b)                b_q <= a_q;
      else if (reg_we_i && reg_sel_i)  b_q <= reg_wdata_i;
    end
  end

  tmr_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (is_out),
    .set_i    (cmp_set | f_set),
    .clr_i    (cmp_clr | f_clr),
    .pol_i    (pol_q),
    .od_i     (od_q),
    .pin_out_o(pin_out_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    ctrl_rdata_o                    = '0;
    ctrl_rdata_o[F_PIN]             = pin_lvl;
    ctrl_rdata_o[F_OD]              = od_q;
    ctrl_rdata_o[F_FRZ]             = frz_q;
    ctrl_rdata_o[F_POL]             = pol_q;
    ctrl_rdata_o[F_BUS +: BSW]      = bsel_q;
    ctrl_rdata_o[F_MODE +: MODE_W]  = mode_q;
  end

  assign reg_a_o = a_q;
  assign reg_b_o = b_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [CTRL_W-1:0] ctrl_rdata_o,
  input logic              freeze_i,
  input logic              flag_o,
  input logic              pin_out_o,
  input logic              pin_oe_o
);
  logic [3:0] cur_mode, wr_mode;
  assign cur_mode = ctrl_rdata_o[F_MODE +: MODE_W];
  assign wr_mode  = ctrl_wdata_i[F_MODE +: MODE_W];

  AST_IN_MODE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_out_mode(cur_mode) |-> (!pin_oe_o && !pin_out_o)) else $error("AST_IN_MODE_NO_DRIVE"); // R13

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_out_mode(cur_mode) && ctrl_rdata_o[F_OD]) |-> !pin_out_o) else $error("AST_OD_NEVER_HIGH"); // R10

  AST_FREEZE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[F_FRZ] && freeze_i) |=> !flag_o) else $error("AST_FREEZE_NO_FLAG"); // R12

  AST_MODE_NO_HOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && cur_mode != 4'd0 && wr_mode != 4'd0 && wr_mode != cur_mode)
    |=> (cur_mode == $past(cur_mode))) else $error("AST_MODE_NO_HOP"); // R4

  AST_FORCE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_rdata_o[F_FCLR:F_FSET] == 2'b00)) else $error("AST_FORCE_READS_ZERO"); // R2

  AST_DIS_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode == 4'd0 && !ctrl_we_i) |=> !flag_o) else $error("AST_DIS_NO_FLAG"); // R1
endmodule

bind dual_cc_timer tmr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .freeze_i    (freeze_i),
  .flag_o      (flag_o),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o)
);

// File: tb/tb_dual_cc_timer.sv
module tb_dual_cc_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] cnt_bus = '0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_a, reg_b;
  logic        freeze = 1'b0;
  logic        pin = 1'b0;
  logic        pin_out, pin_oe, flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cc_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_bus_i(cnt_bus),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_a_o(reg_a), .reg_b_o(reg_b), .freeze_i(freeze), .pin_i(pin),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .flag_o(flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] cw(input logic [3:0] m, input logic [1:0] bs,
                                     input logic pol, input logic frz, input logic od,
                                     input logic fs, input logic fc);
    return {4'b0, m, bs, fc, fs, pol, frz, od, 1'b0};
  endfunction

  task automatic wr_ctrl(input logic [15:0] w);
    ctrl_we = 1'b1; ctrl_wdata = w;
    tick(1);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] v);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic set_bus(input int k, input logic [15:0] v);
    cnt_bus[k*16 +: 16] = v;
  endtask

  task automatic pin_to(input logic v);
    pin = v;
    tick(3);
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrl_rdata, 16'h0000);
    check("R1 reg_a", reg_a, 0);
    check("R1 reg_b", reg_b, 0);
    check("R1 oe", pin_oe, 0);
    check("R1 flag", flag, 0);
  endtask

  task automatic t_icap;
    wr_ctrl(cw(4'd3, 2'd2, 0, 0, 0, 0, 0));
    pin_to(1'b1);
    check("R7 R3 capture bus2", reg_a, 16'h0300);
    check("R5 flag on capture", flag, 1);
    tick(1);
    check("R5 flag one cycle", flag, 0);
    check("R7 B untouched", reg_b, 0);
    set_bus(2, 16'h0333);
    pin_to(1'b0);
    check("R7 no capture on wrong edge", reg_a, 16'h0300);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_ipw;
    wr_ctrl(cw(4'd1, 2'd1, 0, 0, 0, 0, 0));
    pin_to(1'b1);
    check("R5 pol0 A rise", reg_a, 16'h0200);
    set_bus(1, 16'h0250);
    pin_to(1'b0);
    check("R5 pol0 B fall", reg_b, 16'h0250);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
    wr_ctrl(cw(4'd1, 2'd1, 1, 0, 0, 0, 0));
    set_bus(1, 16'h0260);
    pin_to(1'b1);
    check("R5 pol1 B rise", reg_b, 16'h0260);
    check("R5 pol1 A kept", reg_a, 16'h0200);
    set_bus(1, 16'h0270);
    pin_to(1'b0);
    check("R5 pol1 A fall", reg_a, 16'h0270);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_iper;
    wr_ctrl(cw(4'd2, 2'd0, 1, 0, 0, 0, 0));
    pin_to(1'b1);
    pin_to(1'b0);
    check("R6 A period", reg_a, 16'h0100);
    check("R6 B old A", reg_b, 16'h0270);
    set_bus(0, 16'h0180);
    pin_to(1'b1);
    pin_to(1'b0);
    check("R6 A second", reg_a, 16'h0180);
    check("R6 B shifted", reg_b, 16'h0100);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_ocab;
    wr_reg(0, 16'h0010);
    wr_reg(1, 16'h0020);
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 0, 0));
    check("R10 totem oe", pin_oe, 1);
    check("R13 flop cleared on entry", pin_out, 0);
    set_bus(3, 16'h0010); tick(1);
    check("R8 A match sets", pin_out, 1);
    check("R8 flag on A", flag, 1);
    set_bus(3, 16'h0015); tick(1);
    check("R8 no match no flag", flag, 0);
    set_bus(3, 16'h0020); tick(1);
    check("R8 B match clears", pin_out, 0);
    check("R8 flag on B", flag, 1);
    set_bus(3, 16'h0015);
    wr_reg(1, 16'h0010);
    set_bus(3, 16'h0010); tick(1);
    check("R8 B wins tie", pin_out, 0);
    set_bus(3, 16'h0015);
    wr_reg(1, 16'h0020);
    wr_ctrl(cw(4'd5, 2'd3, 1, 0, 0, 0, 0));
    check("R10 pol inverts", pin_out, 1);
    wr_ctrl(cw(4'd5, 2'd3, 1, 0, 1, 0, 0));
    check("R10 od release out", pin_out, 0);
    check("R10 od release oe", pin_oe, 0);
    set_bus(3, 16'h0010); tick(1);
    check("R10 od drive low oe", pin_oe, 1);
    check("R10 od drive low out", pin_out, 0);
    set_bus(3, 16'h0015);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_force;
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 0, 0));
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 1, 0));
    check("R11 force set", pin_out, 1);
    check("R11 force no flag", flag, 0);
    check("R2 force reads 0", ctrl_rdata[5:4], 0);
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 0, 1));
    check("R11 force clear", pin_out, 0);
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 1, 0));
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 1, 1));
    check("R11 both clear", pin_out, 0);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
    wr_ctrl(cw(4'd3, 2'd3, 1, 0, 1, 1, 0));
    check("R13 force ignored oe", pin_oe, 0);
    check("R13 force ignored out", pin_out, 0);
    check("R2 od pol readback", ctrl_rdata[3:1], 3'b101);
    check("R2 mode field", ctrl_rdata[11:8], 4'd3);
  endtask

  task automatic t_hop;
    wr_ctrl(cw(4'd5, 2'd3, 0, 0, 0, 0, 0));
    check("R4 hop blocked", ctrl_rdata[11:8], 4'd3);
    check("R4 still input oe", pin_oe, 0);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_ocb_pwm;
    wr_reg(0, 16'h0030);
    wr_reg(1, 16'h0040);
    wr_ctrl(cw(4'd4, 2'd3, 0, 0, 0, 0, 0));
    wr_ctrl(cw(4'd4, 2'd3, 0, 0, 0, 1, 0));
    set_bus(3, 16'h0030); tick(1);
    check("R9 OCB A ignored pin", pin_out, 1);
    check("R9 OCB A no flag", flag, 0);
    set_bus(3, 16'h0040); tick(1);
    check("R9 OCB B clears", pin_out, 0);
    check("R9 OCB B flag", flag, 1);
    set_bus(3, 16'h0015);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
    wr_ctrl(cw(4'd6, 2'd3, 0, 0, 0, 0, 0));
    set_bus(3, 16'h0030); tick(1);
    check("R9 PWM A sets", pin_out, 1);
    check("R9 PWM A no flag", flag, 0);
    set_bus(3, 16'h0040); tick(1);
    check("R9 PWM B clears", pin_out, 0);
    check("R9 PWM B flag", flag, 1);
    set_bus(3, 16'h0015);
  endtask

  task automatic t_freeze;
    wr_ctrl(cw(4'd6, 2'd3, 0, 1, 0, 0, 0));
    freeze = 1'b1;
    set_bus(3, 16'h0030); tick(2);
    check("R12 frozen no set", pin_out, 0);
    check("R12 frozen no flag", flag, 0);
    freeze = 1'b0; tick(1);
    check("R12 thawed set", pin_out, 1);
    wr_ctrl(cw(4'd6, 2'd3, 0, 0, 0, 0, 0));
    freeze = 1'b1;
    set_bus(3, 16'h0040); tick(1);
    check("R12 freeze ignored", pin_out, 0);
    check("R12 freeze ignored flag", flag, 1);
    freeze = 1'b0;
    set_bus(3, 16'h0015);
    wr_ctrl(cw(4'd0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_pin_status;
    pin = 1'b1; tick(2);
    check("R14 pin status high", ctrl_rdata[0], 1);
    pin = 1'b0; tick(1);
    check("R14 pin status lag", ctrl_rdata[0], 1);
    tick(1);
    check("R14 pin status low", ctrl_rdata[0], 0);
  endtask

  initial begin
    set_bus(0, 16'h0100); set_bus(1, 16'h0200);
    set_bus(2, 16'h0300); set_bus(3, 16'h0400);
    tick(2);
    rst_ni = 1'b1;
    tick(3);
    t_reset();
    t_icap();
    t_ipw();
    t_iper();
    t_ocab();
    t_force();
    t_hop();
    t_ocb_pwm();
    t_freeze();
    t_pin_status();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule